// File: doc/BRIEF.md
# Serial Flash Status Read Responder

This block is the device side of a serial flash status query. It watches the chip-select, serial clock and serial data-in pins of an SPI mode 0 link and collects one 8-bit command after chip select falls. If the command is the status-read code, the block shifts a one-byte status word out on the data-out pin, most significant bit first. It keeps repeating that byte for as long as chip select stays low and the clock keeps running. The block takes a new copy of the live status inputs at the start of every repeated byte.

The pins are oversampled by a faster system clock. Each pin passes through a synchronizer and an edge detector, so all state runs in one clock domain. The status fields come from synchronous input ports: busy, compare result, sector protection and page-size mode. The density code is a fixed parameter. The data-out pin is driven only while status bytes are being shifted. At all other times the output enable is low, and a pad outside the block tri-states the line.

Top module: `flash_status_responder`

## Requirements
- R1: During and right after reset, `spi_miso_oe` is 0 and `spi_miso` is 0.
- R2: After chip select falls, the first 8 rising SCK edges shift the command in MSB first. `spi_miso_oe` stays 0 while the command is being received.
- R3: When the command equals 0xD7, the falling SCK edge after the 8th rising edge drives status bit 7 and raises `spi_miso_oe`. Each later falling edge drives the next lower bit. The value is valid at the next rising edge.
- R4: Status layout: bit 7 = NOT `st_busy` (1 = ready); bit 6 = `st_cmp_diff` (1 = compare mismatch); bits 5..2 = density code 1111; bit 1 = `st_protect`; bit 0 = `st_page_pow2` (1 = 1024-byte page, 0 = 1056-byte page).
- R5: After bit 0, the next falling edge starts the byte again at bit 7. This continues for as long as chip select stays low.
- R6: The status inputs are captured once per byte, at the falling edge that drives bit 7. A change to the inputs in the middle of a byte does not alter that byte, and it does appear in the next byte.
- R7: Any other command leaves `spi_miso_oe` at 0 for the rest of the chip-select period, whatever happens on SCK and MOSI. A later period with command 0xD7 still works.
- R8: Chip select going high at any point clears the bit counter and the command decoder, and drops `spi_miso_oe` within SYNC_STAGES+2 system clocks. A partial command is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock pin, idles low (mode 0) |
| spi_cs_n | input | 1 | Chip select pin, active low |
| spi_mosi | input | 1 | Serial data from the host |
| st_busy | input | 1 | Device busy (sent inverted as the ready bit) |
| st_cmp_diff | input | 1 | Last page-to-buffer compare found a difference |
| st_protect | input | 1 | Sector protection enabled |
| st_page_pow2 | input | 1 | Page size is the 1024-byte mode |
| spi_miso | output | 1 | Serial status data to the host |
| spi_miso_oe | output | 1 | Enable for the data-out pad driver |

## Verification
The hardest case to reach is a status change that lands in the middle of a byte, with no torn byte as the result. The bench changes the status inputs after the third bit of a byte and again before the last bit of the next byte. It expects the first byte to stay unchanged and the following bytes to carry the new values. Aborts are covered in three ways: chip select rises partway through a command, chip select rises partway through a status byte, and a command differs from the status code only in its top or bottom bit. After each abort, a clean status read follows.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

  localparam int unsigned OPCODE_W = 8;
  localparam int unsigned STAT_W   = 8;

  typedef enum logic [1:0] {
    DEC_SHIFT  = 2'd0,
    DEC_STATUS = 2'd1,
    DEC_IGNORE = 2'd2
  } dec_state_e;

  function automatic logic [STAT_W-1:0] pack_status(
    input logic       busy,
    input logic       cmp_diff,
    input logic [3:0] density,
    input logic       protect,
    input logic       page_pow2
  );
    return {~busy, cmp_diff, density, protect, page_pow2};
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned NUM    = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [NUM-1:0] RST_VAL = '0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NUM-1:0] d,
  output logic [NUM-1:0] q
);

  for (genvar g = 0; g < NUM; g++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[g]}};
      else     chain <= {chain[STAGES-2:0], d[g]};
    end
    assign q[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/stat_opcode_decoder.sv
module stat_opcode_decoder
  import flash_stat_pkg::*;
#(
  parameter logic [OPCODE_W-1:0] STATUS_OPCODE = 8'hD7
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_idle,
  input  logic sck_rise,
  input  logic mosi,
  output logic stat_active
);

  localparam int unsigned CNT_W = $clog2(OPCODE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(OPCODE_W - 1);

  dec_state_e          state;
  logic [CNT_W-1:0]    bit_cnt;
  logic [OPCODE_W-1:0] opc_sr;
  logic [OPCODE_W-1:0] opc_next;

  assign opc_next = {opc_sr[OPCODE_W-2:0], mosi};

  always_ff @(posedge clk) begin
    if (rst || cs_idle) begin
      state   <= DEC_SHIFT;
      bit_cnt <= '0;
      opc_sr  <= '0;
    end else if (sck_rise && state == DEC_SHIFT) begin
      opc_sr <= opc_next;
      if (bit_cnt == LAST_BIT) begin
        bit_cnt <= '0;
        state   <= (opc_next == STATUS_OPCODE) ? DEC_STATUS : DEC_IGNORE;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  assign stat_active = (state == DEC_STATUS);

endmodule

// File: rtl/stat_shifter.sv
module stat_shifter
  import flash_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_idle,
  input  logic              stat_active,
  input  logic              sck_fall,
  input  logic [STAT_W-1:0] live_status,
  output logic              miso,
  output logic              miso_oe
);

  localparam int unsigned CNT_W = $clog2(STAT_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(STAT_W - 1);

  logic [STAT_W-1:0] shreg;
  logic [CNT_W-1:0]  pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      pos     <= '0;
      miso    <= 1'b0;
      miso_oe <= 1'b0;
    end else if (cs_idle) begin
      pos     <= '0;
      miso_oe <= 1'b0;
    end else if (stat_active && sck_fall) begin
      miso_oe <= 1'b1;
      if (pos == '0) begin
        miso  <= live_status[STAT_W-1];
        shreg <= {live_status[STAT_W-2:0], 1'b0};
      end else begin
        miso  <= shreg[STAT_W-1];
        shreg <= {shreg[STAT_W-2:0], 1'b0};
      end
      pos <= (pos == LAST_BIT) ? '0 : pos + 1'b1;
    end
  end

endmodule

// File: rtl/flash_status_responder.sv
module flash_status_responder
  import flash_stat_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [OPCODE_W-1:0] STATUS_OPCODE = 8'hD7,
  parameter logic [3:0] DENSITY_CODE = 4'hF
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  input  logic st_busy,
  input  logic st_cmp_diff,
  input  logic st_protect,
  input  logic st_page_pow2,
  output logic spi_miso,
  output logic spi_miso_oe
);

  localparam int unsigned PIN_N = 3;

  logic [PIN_N-1:0]  pins_q;
  logic              sck_q, cs_n_q, mosi_q, sck_d;
  logic              sck_rise, sck_fall;
  logic              stat_active;
  logic [STAT_W-1:0] live_status;

  spi_pin_sync #(
    .NUM    (PIN_N),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b010)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  ({spi_mosi, spi_cs_n, spi_sck}),
    .q  (pins_q)
  );

  assign sck_q  = pins_q[0];
  assign cs_n_q = pins_q[1];
  assign mosi_q = pins_q[2];

  always_ff @(posedge clk) begin
    if (rst) sck_d <= 1'b0;
    else     sck_d <= sck_q;
  end

  assign sck_rise = sck_q & ~sck_d;
  assign sck_fall = ~sck_q & sck_d;

  assign live_status = pack_status(st_busy, st_cmp_diff, DENSITY_CODE,
                                   st_protect, st_page_pow2);

  stat_opcode_decoder #(
    .STATUS_OPCODE(STATUS_OPCODE)
  ) u_dec (
    .clk        (clk),
    .rst        (rst),
    .cs_idle    (cs_n_q),
    .sck_rise   (sck_rise),
    .mosi       (mosi_q),
    .stat_active(stat_active)
  );

  stat_shifter u_shift (
    .clk        (clk),
    .rst        (rst),
    .cs_idle    (cs_n_q),
    .stat_active(stat_active),
    .sck_fall   (sck_fall),
    .live_status(live_status),
    .miso       (spi_miso),
    .miso_oe    (spi_miso_oe)
  );

endmodule

// File: rtl/flash_status_checker.sv
module flash_status_checker (
  input logic clk,
  input logic rst,
  input logic cs_n_q,
  input logic sck_fall,
  input logic stat_active,
  input logic spi_miso,
  input logic spi_miso_oe
);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!spi_miso_oe && !spi_miso));

  assert_oe_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_miso_oe) |-> ($past(sck_fall) && $past(stat_active)));

  assert_hold_between_falls_R3: assert property (@(posedge clk) disable iff (rst)
    !sck_fall |=> $stable(spi_miso));

  assert_oe_needs_status_R7: assert property (@(posedge clk) disable iff (rst)
    spi_miso_oe |-> stat_active);

  assert_cs_release_R8: assert property (@(posedge clk) disable iff (rst)
    cs_n_q |=> !spi_miso_oe);

endmodule

bind flash_status_responder flash_status_checker u_flash_status_checker (
  .clk        (clk),
  .rst        (rst),
  .cs_n_q     (cs_n_q),
  .sck_fall   (sck_fall),
  .stat_active(stat_active),
  .spi_miso   (spi_miso),
  .spi_miso_oe(spi_miso_oe)
);

// File: tb/test_flash_status_responder.sv
module test_flash_status_responder;

  localparam int HALF = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic busy = 1'b0, diff = 1'b0, prot = 1'b0, pow2 = 1'b0;
  logic miso, oe;

  int compared = 0;
  int mismatched = 0;

  int       nrise, mode, k, rxn;
  bit [7:0] opc_m, snap, rx;
  bit       exp_oe, exp_bit;
  bit [7:0] rxq[$];

  flash_status_responder i_flash_status_responder (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .st_busy(busy), .st_cmp_diff(diff), .st_protect(prot), .st_page_pow2(pow2),
    .spi_miso(miso), .spi_miso_oe(oe)
  );

  task automatic cmp(string req, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit [7:0] live();
    return {~busy, diff, 4'b1111, prot, pow2};
  endfunction

  task automatic spi_bit(bit b);
    mosi = b;
    repeat (HALF) @(negedge clk);
    if (mode == 0)      cmp("R2 enable low while command arrives", {7'd0, oe}, 8'd0);
    else if (mode == 2) cmp("R7 enable low after foreign command", {7'd0, oe}, 8'd0);
    else begin
      cmp("R3 enable high in status phase", {7'd0, oe}, {7'd0, exp_oe});
      cmp($sformatf("R4 status bit %0d", 7 - ((k - 1) % 8)), {7'd0, miso}, {7'd0, exp_bit});
      rx = {rx[6:0], miso};
      rxn++;
      if (rxn == 8) begin
        rxq.push_back(rx);
        rxn = 0;
      end
    end
    sck = 1'b1;
    if (mode == 0) begin
      opc_m = {opc_m[6:0], b};
      nrise++;
      if (nrise == 8) mode = (opc_m == 8'hD7) ? 1 : 2;
    end
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
    if (mode == 1) begin
      if (k % 8 == 0) snap = live();
      exp_bit = snap[7 - (k % 8)];
      exp_oe  = 1'b1;
      k++;
    end
  endtask

  task automatic send_byte(bit [7:0] v);
    for (int i = 7; i >= 0; i--) spi_bit(v[i]);
  endtask

  task automatic start_cs();
    mode = 0; nrise = 0; opc_m = 0; k = 0; rxn = 0; exp_oe = 0;
    rxq.delete();
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic end_cs();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    exp_oe = 0;
    repeat (5) @(negedge clk);
    cmp("R8 enable released after chip select rises", {7'd0, oe}, 8'd0);
    repeat (HALF) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : stim
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cmp("R1 enable after reset", {7'd0, oe}, 8'd0);
    cmp("R1 data after reset", {7'd0, miso}, 8'd0);

    // R4, R5: fixed status repeated
    busy = 1; diff = 0; prot = 1; pow2 = 0;
    start_cs();
    send_byte(8'hD7);
    send_byte(8'hA5);
    send_byte(8'h00);
    end_cs();
    cmp("R5 bytes received", 8'(rxq.size()), 8'd2);
    cmp("R4 first byte", rxq[0], 8'h3E);
    cmp("R5 repeated byte", rxq[1], 8'h3E);

    // R6: change in the middle of a byte
    busy = 0; diff = 1; prot = 0; pow2 = 1;
    start_cs();
    send_byte(8'hD7);
    repeat (3) spi_bit(1'b0);
    busy = 1; diff = 0; prot = 0; pow2 = 0;
    repeat (5) spi_bit(1'b1);
    repeat (7) spi_bit(1'b0);
    busy = 0; diff = 0; prot = 1; pow2 = 1;
    spi_bit(1'b0);
    send_byte(8'h3C);
    end_cs();
    cmp("R6 byte not torn", rxq[0], 8'hFD);
    cmp("R6 fresh copy next byte", rxq[1], 8'h3C);
    cmp("R6 fresh copy third byte", rxq[2], 8'hBF);

    // R7: foreign command, top bit differs
    start_cs();
    send_byte(8'h57);
    send_byte(8'hD7);
    send_byte(8'hFF);
    end_cs();
    cmp("R7 no bytes after foreign command", 8'(rxq.size()), 8'd0);

    // R8: partial command, then clean read, then abort mid-byte
    start_cs();
    spi_bit(1); spi_bit(1); spi_bit(0); spi_bit(1);
    end_cs();
    busy = 0; diff = 0; prot = 0; pow2 = 0;
    start_cs();
    send_byte(8'hD7);
    send_byte(8'h00);
    repeat (3) spi_bit(1'b0);
    end_cs();
    cmp("R8 read after partial command", rxq[0], 8'hBC);

    // R7: foreign command, bottom bit differs, then a clean read
    start_cs();
    send_byte(8'hD6);
    send_byte(8'h00);
    end_cs();
    cmp("R7 no bytes after near-miss command", 8'(rxq.size()), 8'd0);
    busy = 1; diff = 0; prot = 1; pow2 = 0;
    start_cs();
    send_byte(8'hD7);
    send_byte(8'h00);
    end_cs();
    cmp("R7 status read after ignored period", rxq[0], 8'h3E);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule